// File: doc/BRIEF.md
# Programming-Mode Configuration Download Receiver

This block sits behind a two-line programming port made of a clock line and a data line. After reset it times the clock line to decide whether a programmer is attached. If the entry pattern is met, it takes in an 80-bit package made of an 8-byte secret code, one configuration byte and one checksum byte. It then checks that the ten bytes sum to zero modulo 256.

A package that passes is offered to the non-volatile store as one write item, using a valid/done handshake. `wr_valid_o` rises with the code and the configuration byte, and both stay frozen until the store pulses `wr_done_i`. The store may hold off as long as it likes. There is no timeout on the handshake, and nothing else moves while it is pending. Once the write completes, the block drives an acknowledge pulse toward the data line. It then asks for an erase of all learned transmitters.

A failed entry pattern, a clock phase that stays too long, or a bad checksum ends the session quietly: no write, no acknowledge and no erase. Only one download is taken per reset. All timing comes from `tick_i`, a one-cycle enable that pulses `TICKS_PER_MS` times per millisecond (4 by default).

Top module: `cfgdl_config_rx`

## Requirements
- R1: Reset must be released with the programming clock line low. Entry then requires the line to stay low for at least 1 ms. The line must also rise no later than 64 ms after reset. Otherwise no download takes place in that reset period.
- R2: After the entry rise, the clock line must stay high for more than 8 ms and no more than 128 ms. Its falling edge starts the package. A high phase outside that range cancels the download.
- R3: The 80 package bits are sampled on the falling edges of the clock line. Byte 0 comes first and each byte is least significant bit first. Bytes 0 to 7 appear as `wr_code_o[8k+7:8k]` for byte k, byte 8 appears as `wr_cfg_o`, and byte 9 is the checksum.
- R4: A package is accepted only if the 8-bit sum of all ten bytes, carries dropped, is zero. For example, code 0x0123456789ABCDEF with configuration 0x01 needs checksum 0x3F. A failing package gives no write, no acknowledge and no erase.
- R5: The configuration byte is decoded as follows: bit 0 drives `cfg_alg_xor_o` (0 = decrypt, 1 = XOR), bit 2 drives `cfg_secure_o` and bit 3 drives `cfg_sleep_o`. Bits 1 and 4 to 7 affect none of these outputs.
- R6: `wr_valid_o` stays high with `wr_code_o` and `wr_cfg_o` unchanged until a cycle in which `wr_done_i` is high, and it falls on the next cycle.
- R7: After the write completes, `ack_o` rises within 1 ms. It then stays high for at least 1 ms and at most 2 ms.
- R8: After the acknowledge ends, `erase_req_o` pulses for exactly one cycle, in the cycle right after `ack_o` falls.
- R9: During the package, a clock phase (high or low) longer than 320 ms aborts the download with no write and no acknowledge.
- R10: After reset, `wr_valid_o`, `ack_o` and `erase_req_o` are low. Once a download has finished or failed, further activity on the lines is ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Timebase enable, TICKS_PER_MS pulses per millisecond |
| prog_clk_i | input | 1 | Programming clock line (asynchronous) |
| prog_data_i | input | 1 | Programming data line (asynchronous) |
| wr_valid_o | output | 1 | Write item offered to the store |
| wr_code_o | output | 64 | Secret code, byte k at bits 8k+7:8k |
| wr_cfg_o | output | 8 | Raw configuration byte |
| wr_done_i | input | 1 | Store has finished the write |
| cfg_alg_xor_o | output | 1 | Key-generation algorithm select |
| cfg_secure_o | output | 1 | Secure learn enable |
| cfg_sleep_o | output | 1 | Sleep enable |
| ack_o | output | 1 | Acknowledge pulse to be driven onto the data line |
| erase_req_o | output | 1 | One-cycle request to erase all learned transmitters |

## Verification
Most internal faults show up as a missing or stray write item. A bit counter that is off by one, or a wrong shift direction, makes the ten bytes fail the checksum or scrambles `wr_code_o`. Either effect is visible in the first cycle `wr_valid_o` should rise, about two cycles after the 80th falling edge. Timer faults in entry, hold or phase checking show up as a write that should not appear, or a missing one, by the end of the package. A sequencing fault after the write shows up within a few milliseconds, as a wrong acknowledge delay or width, or an erase pulse that is absent, doubled, or out of order with the acknowledge.

// File: rtl/cfgdl_pkg.sv
package cfgdl_pkg;
  localparam int BYTE_W      = 8;
  localparam int CODE_BYTES  = 8;
  localparam int PKG_BYTES   = CODE_BYTES + 2;
  localparam int PKG_BITS    = PKG_BYTES * BYTE_W;
  localparam int CFG_LSB     = CODE_BYTES * BYTE_W;
  localparam int CFG_ALG_BIT = 0;
  localparam int CFG_SEC_BIT = 2;
  localparam int CFG_SLP_BIT = 3;

  typedef enum logic [1:0] {
    EN_WAIT, EN_HOLD, EN_PASS, EN_FAIL
  } entry_st_t;

  typedef enum logic [2:0] {
    TP_ENTRY, TP_RECV, TP_WRITE, TP_GAP, TP_ACK, TP_ERASE, TP_IDLE
  } top_st_t;
endpackage

// File: rtl/cfgdl_line_sync.sv
module cfgdl_line_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] level_o
);
  logic [STAGES-1:0][W-1:0] sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq <= '0;
    end else begin
      sq[0] <= line_i;
      for (int s = 1; s < STAGES; s++) sq[s] <= sq[s-1];
    end
  end

  assign level_o = sq[STAGES-1];
endmodule

// File: rtl/cfgdl_entry_timer.sv
module cfgdl_entry_timer
  import cfgdl_pkg::*;
#(
  parameter int LOW_MIN  = 4,
  parameter int RISE_MAX = 256,
  parameter int HOLD_MIN = 32,
  parameter int HOLD_MAX = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic lvl_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic pass_o,
  output logic fail_o
);
  localparam int EW = $clog2(RISE_MAX + 2);
  localparam int HW = $clog2(HOLD_MAX + 2);
  localparam int LW = $clog2(LOW_MIN + 1);
  localparam logic [EW-1:0] RISE_LIM = EW'(RISE_MAX);
  localparam logic [HW-1:0] HOLD_LO  = HW'(HOLD_MIN);
  localparam logic [HW-1:0] HOLD_HI  = HW'(HOLD_MAX);
  localparam logic [LW-1:0] LOW_LIM  = LW'(LOW_MIN);

  entry_st_t      st_q;
  logic [EW-1:0]  since_q;
  logic [HW-1:0]  hold_q;
  logic [LW-1:0]  low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= EN_WAIT;
      since_q <= '0;
      hold_q  <= '0;
      low_q   <= '0;
    end else begin
      case (st_q)
        EN_WAIT: begin
          if (tick_i && since_q <= RISE_LIM) since_q <= since_q + EW'(1);
          if (lvl_i) low_q <= '0;
          else if (tick_i && low_q != LOW_LIM) low_q <= low_q + LW'(1);
          if (rise_i) begin
            hold_q <= '0;
            st_q   <= (low_q == LOW_LIM && since_q <= RISE_LIM) ? EN_HOLD : EN_FAIL;
          end else if (since_q > RISE_LIM) begin
            st_q <= EN_FAIL;
          end
        end
        EN_HOLD: begin
          if (fall_i) st_q <= (hold_q > HOLD_LO) ? EN_PASS : EN_FAIL;
          else if (hold_q > HOLD_HI) st_q <= EN_FAIL;
          else if (tick_i) hold_q <= hold_q + HW'(1);
        end
        default: st_q <= st_q;
      endcase
    end
  end

  assign pass_o = (st_q == EN_PASS);
  assign fail_o = (st_q == EN_FAIL);
endmodule

// File: rtl/cfgdl_pkt_rx.sv
module cfgdl_pkt_rx
  import cfgdl_pkg::*;
#(
  parameter int PHASE_MAX = 1280
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                tick_i,
  input  logic                edge_i,
  input  logic                fall_i,
  input  logic                data_i,
  output logic                full_o,
  output logic                abort_o,
  output logic                sum_ok_o,
  output logic [PKG_BITS-1:0] pkt_o
);
  localparam int CW = $clog2(PKG_BITS + 1);
  localparam int PW = $clog2(PHASE_MAX + 2);
  localparam logic [CW-1:0] BIT_LAST  = CW'(PKG_BITS);
  localparam logic [PW-1:0] PHASE_LIM = PW'(PHASE_MAX);

  logic [CW-1:0]       bit_q;
  logic [PW-1:0]       phase_q;
  logic [PKG_BITS-1:0] pkt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      phase_q <= '0;
      pkt_q   <= '0;
    end else if (!en_i) begin
      bit_q   <= '0;
      phase_q <= '0;
    end else begin
      if (edge_i) phase_q <= '0;
      else if (tick_i && phase_q <= PHASE_LIM) phase_q <= phase_q + PW'(1);
      if (fall_i && bit_q != BIT_LAST) begin
        pkt_q <= {data_i, pkt_q[PKG_BITS-1:1]};
        bit_q <= bit_q + CW'(1);
      end
    end
  end

  logic [BYTE_W-1:0] bytes [PKG_BYTES];
  for (genvar g = 0; g < PKG_BYTES; g++) begin : g_slice
    assign bytes[g] = pkt_q[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    logic [BYTE_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < PKG_BYTES; k++) acc = acc + bytes[k];
    sum_ok_o = (acc == '0);
  end

  assign full_o  = (bit_q == BIT_LAST);
  assign abort_o = (phase_q > PHASE_LIM);
  assign pkt_o   = pkt_q;
endmodule

// File: rtl/cfgdl_config_rx.sv
module cfgdl_config_rx
  import cfgdl_pkg::*;
#(
  parameter int TICKS_PER_MS = 4,
  parameter int LOW_MIN_MS   = 1,
  parameter int RISE_MAX_MS  = 64,
  parameter int HOLD_MIN_MS  = 8,
  parameter int HOLD_MAX_MS  = 128,
  parameter int PHASE_MAX_MS = 320,
  parameter int ACK_GAP_MS   = 1,
  parameter int ACK_LEN_MS   = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        prog_clk_i,
  input  logic        prog_data_i,
  output logic        wr_valid_o,
  output logic [63:0] wr_code_o,
  output logic [7:0]  wr_cfg_o,
  input  logic        wr_done_i,
  output logic        cfg_alg_xor_o,
  output logic        cfg_secure_o,
  output logic        cfg_sleep_o,
  output logic        ack_o,
  output logic        erase_req_o
);
  localparam int GAP_T = ACK_GAP_MS * TICKS_PER_MS;
  localparam int ACK_T = ACK_LEN_MS * TICKS_PER_MS;
  localparam int SEQ_MAX = (GAP_T > ACK_T) ? GAP_T : ACK_T;
  localparam int SW = $clog2(SEQ_MAX + 1);
  localparam logic [SW-1:0] GAP_END = SW'(GAP_T - 1);
  localparam logic [SW-1:0] ACK_END = SW'(ACK_T - 1);

  logic [1:0] lvl;
  logic       clk_prev_q;
  logic       line_rise, line_fall;

  cfgdl_line_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  ({prog_data_i, prog_clk_i}),
    .level_o (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev_q <= 1'b0;
    else        clk_prev_q <= lvl[0];
  end
  assign line_rise = lvl[0] & ~clk_prev_q;
  assign line_fall = ~lvl[0] & clk_prev_q;

  logic entry_pass, entry_fail;

  cfgdl_entry_timer #(
    .LOW_MIN  (LOW_MIN_MS  * TICKS_PER_MS),
    .RISE_MAX (RISE_MAX_MS * TICKS_PER_MS),
    .HOLD_MIN (HOLD_MIN_MS * TICKS_PER_MS),
    .HOLD_MAX (HOLD_MAX_MS * TICKS_PER_MS)
  ) u_entry (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .lvl_i  (lvl[0]),
    .rise_i (line_rise),
    .fall_i (line_fall),
    .pass_o (entry_pass),
    .fail_o (entry_fail)
  );

  top_st_t             st_q;
  logic [SW-1:0]       seq_q;
  logic                rx_full, rx_abort, rx_sum_ok;
  logic [PKG_BITS-1:0] rx_pkt;

  cfgdl_pkt_rx #(.PHASE_MAX(PHASE_MAX_MS * TICKS_PER_MS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (st_q == TP_RECV),
    .tick_i   (tick_i),
    .edge_i   (line_rise | line_fall),
    .fall_i   (line_fall),
    .data_i   (lvl[1]),
    .full_o   (rx_full),
    .abort_o  (rx_abort),
    .sum_ok_o (rx_sum_ok),
    .pkt_o    (rx_pkt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TP_ENTRY;
      seq_q <= '0;
    end else begin
      case (st_q)
        TP_ENTRY: begin
          if (entry_pass)      st_q <= TP_RECV;
          else if (entry_fail) st_q <= TP_IDLE;
        end
        TP_RECV: begin
          if (rx_abort)     st_q <= TP_IDLE;
          else if (rx_full) st_q <= rx_sum_ok ? TP_WRITE : TP_IDLE;
        end
        TP_WRITE: begin
          if (wr_done_i) begin
            st_q  <= TP_GAP;
            seq_q <= '0;
          end
        end
        TP_GAP: begin
          if (tick_i) begin
            if (seq_q == GAP_END) begin
              st_q  <= TP_ACK;
              seq_q <= '0;
            end else begin
              seq_q <= seq_q + SW'(1);
            end
          end
        end
        TP_ACK: begin
          if (tick_i) begin
            if (seq_q == ACK_END) st_q <= TP_ERASE;
            else                  seq_q <= seq_q + SW'(1);
          end
        end
        TP_ERASE: st_q <= TP_IDLE;
        default:  st_q <= TP_IDLE;
      endcase
    end
  end

  assign wr_valid_o    = (st_q == TP_WRITE);
  assign ack_o         = (st_q == TP_ACK);
  assign erase_req_o   = (st_q == TP_ERASE);
  assign wr_code_o     = rx_pkt[CFG_LSB-1:0];
  assign wr_cfg_o      = rx_pkt[CFG_LSB +: BYTE_W];
  assign cfg_alg_xor_o = wr_cfg_o[CFG_ALG_BIT];
  assign cfg_secure_o  = wr_cfg_o[CFG_SEC_BIT];
  assign cfg_sleep_o   = wr_cfg_o[CFG_SLP_BIT];
endmodule

// File: rtl/cfgdl_rx_checker.sv
module cfgdl_rx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid_o,
  input logic        wr_done_i,
  input logic [63:0] wr_code_o,
  input logic [7:0]  wr_cfg_o,
  input logic        ack_o,
  input logic        erase_req_o
);
  logic finished_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           finished_q <= 1'b0;
    else if (erase_req_o) finished_q <= 1'b1;
  end

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_done_i |=> wr_valid_o && $stable(wr_code_o) && $stable(wr_cfg_o));

  // R6
  wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_valid_o) |-> $past(wr_done_i));

  // R7
  ack_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid_o, ack_o, erase_req_o}));

  // R8
  erase_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_o |-> $past(ack_o));

  // R8
  erase_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req_o |=> !erase_req_o);

  // R10
  once_per_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finished_q |-> !wr_valid_o && !ack_o);
endmodule

bind cfgdl_config_rx cfgdl_rx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_valid_o  (wr_valid_o),
  .wr_done_i   (wr_done_i),
  .wr_code_o   (wr_code_o),
  .wr_cfg_o    (wr_cfg_o),
  .ack_o       (ack_o),
  .erase_req_o (erase_req_o)
);

// File: tb/cfgdl_config_rx_bench.sv
module cfgdl_config_rx_bench;
  localparam int TPM      = 4;
  localparam int TICK_DIV = 2;
  localparam int GAP_T    = 1 * TPM;
  localparam int ACK_T    = 2 * TPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic prog_clk_i = 1'b0;
  logic prog_data_i = 1'b0;
  logic wr_done_i = 1'b0;
  logic wr_valid_o, cfg_alg_xor_o, cfg_secure_o, cfg_sleep_o, ack_o, erase_req_o;
  logic [63:0] wr_code_o;
  logic [7:0]  wr_cfg_o;

  always #10 clk = ~clk;

  cfgdl_config_rx u_cfgdl_config_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .prog_clk_i(prog_clk_i), .prog_data_i(prog_data_i),
    .wr_valid_o(wr_valid_o), .wr_code_o(wr_code_o), .wr_cfg_o(wr_cfg_o),
    .wr_done_i(wr_done_i), .cfg_alg_xor_o(cfg_alg_xor_o),
    .cfg_secure_o(cfg_secure_o), .cfg_sleep_o(cfg_sleep_o),
    .ack_o(ack_o), .erase_req_o(erase_req_o)
  );

  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % TICK_DIV;
    tick_i <= (tick_cnt == 0);
  end

  int checks = 0, errors = 0;
  int exp_writes = 0, handled = 0, ack_rises = 0, erase_pulses = 0, exp_acks = 0;
  logic ack_prev = 1'b0, erase_prev = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ack_o && !ack_prev) ack_rises++;
      if (erase_req_o && !erase_prev) erase_pulses++;
    end
    ack_prev = ack_o;
    erase_prev = erase_req_o;
  end

  typedef struct { logic [63:0] code; logic [7:0] cfg; } exp_t;
  exp_t exp_q[$];

  // Monitor: pops the scoreboard when a write item appears.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && wr_valid_o) begin
        exp_t e;
        int n;
        bit held;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected write", wr_code_o, 64'h0);
          e.code = wr_code_o; e.cfg = wr_cfg_o;
        end else begin
          e = exp_q.pop_front();
        end
        check(wr_code_o == e.code, "R3 code bytes", wr_code_o, e.code);
        check(wr_cfg_o == e.cfg, "R3 config byte", {56'h0, wr_cfg_o}, {56'h0, e.cfg});
        check({cfg_alg_xor_o, cfg_secure_o, cfg_sleep_o} == {e.cfg[0], e.cfg[2], e.cfg[3]},
              "R5 config decode", {61'h0, cfg_alg_xor_o, cfg_secure_o, cfg_sleep_o},
              {61'h0, e.cfg[0], e.cfg[2], e.cfg[3]});
        held = 1'b1;
        for (int i = 0; i < 7; i++) begin
          @(negedge clk);
          if (!wr_valid_o || ack_o || wr_code_o != e.code || wr_cfg_o != e.cfg) held = 1'b0;
        end
        check(held, "R6 item held under back-pressure", {63'h0, held}, 64'h1);
        wr_done_i = 1'b1;
        @(negedge clk);
        wr_done_i = 1'b0;
        check(!wr_valid_o, "R6 valid drops after done", {63'h0, wr_valid_o}, 64'h0);
        n = 0;
        while (!ack_o && n < 100) begin @(negedge clk); n++; end
        check(ack_o && n <= (GAP_T + 1) * TICK_DIV, "R7 ack start delay", n, (GAP_T + 1) * TICK_DIV);
        n = 0;
        while (ack_o && n < 200) begin @(negedge clk); n++; end
        check(n >= (ACK_T - 1) * TICK_DIV && n <= ACK_T * TICK_DIV + 1, "R7 ack width", n, ACK_T * TICK_DIV);
        check(erase_req_o, "R8 erase after ack", {63'h0, erase_req_o}, 64'h1);
        @(negedge clk);
        check(!erase_req_o, "R8 erase one cycle", {63'h0, erase_req_o}, 64'h0);
        handled++;
      end
    end
  end

  function automatic logic [7:0] csum(input logic [63:0] code, input logic [7:0] cfg);
    logic [7:0] s;
    s = cfg;
    for (int k = 0; k < 8; k++) s = s + code[8*k +: 8];
    return 8'(8'h00 - s);
  endfunction

  task automatic wait_ticks(input int n);
    repeat (n * TICK_DIV) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; prog_clk_i = 1'b0; prog_data_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_pkg(input logic [63:0] code, input logic [7:0] cfg, input logic [7:0] chk,
                          input int stall_ticks);
    logic [79:0] bits;
    bits = {chk, cfg, code};
    for (int b = 0; b < 80; b++) begin
      if (b == 40 && stall_ticks > 0) wait_ticks(stall_ticks);
      prog_data_i = bits[b];
      wait_ticks(1);
      prog_clk_i = 1'b1;
      wait_ticks(2);
      prog_clk_i = 1'b0;
      wait_ticks(2);
    end
  endtask

  task automatic session(input string req, input bit with_reset, input int low_t, input int hold_t,
                         input logic [63:0] code, input logic [7:0] cfg, input bit corrupt,
                         input int stall_ticks, input bit expect_write);
    logic [7:0] chk;
    exp_t e;
    chk = csum(code, cfg) ^ (corrupt ? 8'h10 : 8'h00);
    if (with_reset) do_reset();
    if (expect_write) begin
      e.code = code; e.cfg = cfg;
      exp_q.push_back(e);
      exp_writes++; exp_acks++;
    end
    wait_ticks(low_t);
    prog_clk_i = 1'b1;
    wait_ticks(hold_t);
    prog_clk_i = 1'b0;
    wait_ticks(2);
    send_pkg(code, cfg, chk, stall_ticks);
    wait_ticks(40);
    check(handled == exp_writes, {req, " write count"}, handled, exp_writes);
    check(ack_rises == exp_acks && erase_pulses == exp_acks, {req, " ack/erase count"},
          {ack_rises[31:0], erase_pulses[31:0]}, {exp_acks[31:0], exp_acks[31:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R10 reset state
    do_reset();
    @(negedge clk);
    check(!wr_valid_o && !ack_o && !erase_req_o, "R10 reset outputs",
          {61'h0, wr_valid_o, ack_o, erase_req_o}, 64'h0);
    // R4 worked checksum example
    check(csum(64'h0123456789ABCDEF, 8'h01) == 8'h3F, "R4 checksum example",
          {56'h0, csum(64'h0123456789ABCDEF, 8'h01)}, 64'h3F);
    // R1 R2 R3 R4 valid download
    session("R3 good package", 1'b1, 8, 48, 64'h0123456789ABCDEF, 8'h01, 1'b0, 0, 1'b1);
    // R5 secure and sleep set
    session("R5 cfg 0C", 1'b1, 8, 48, 64'hA55A_F00F_1234_C3D2, 8'h0C, 1'b0, 0, 1'b1);
    // R10 second package without reset is ignored
    session("R10 no second download", 1'b0, 8, 48, 64'h1111_2222_3333_4444, 8'h01, 1'b0, 0, 1'b0);
    // R5 unused bits ignored
    session("R5 cfg F2", 1'b1, 8, 48, 64'hFEDC_BA98_7654_3210, 8'hF2, 1'b0, 0, 1'b1);
    // R4 bad checksum
    session("R4 bad checksum", 1'b1, 8, 48, 64'h0123456789ABCDEF, 8'h01, 1'b1, 0, 1'b0);
    // R1 low too short
    session("R1 low too short", 1'b1, 2, 48, 64'h0123456789ABCDEF, 8'h01, 1'b0, 0, 1'b0);
    // R1 rise too late
    session("R1 rise too late", 1'b1, 280, 48, 64'h0123456789ABCDEF, 8'h01, 1'b0, 0, 1'b0);
    // R2 hold too short
    session("R2 hold too short", 1'b1, 8, 24, 64'h0123456789ABCDEF, 8'h01, 1'b0, 0, 1'b0);
    // R2 hold too long
    session("R2 hold too long", 1'b1, 8, 560, 64'h0123456789ABCDEF, 8'h01, 1'b0, 0, 1'b0);
    // R9 phase timeout mid package
    session("R9 phase timeout", 1'b1, 8, 48, 64'h0123456789ABCDEF, 8'h01, 1'b0, 1300, 1'b0);
    // R3 a second good package after the failures
    session("R3 good package 2", 1'b1, 8, 48, 64'h8070_6050_4030_2010, 8'h09, 1'b0, 0, 1'b1);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule